// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave side of the serial command port of a NOR flash memory, working in SPI mode 0. The host lowers chip select, clocks in a one-byte opcode with the most significant bit first, then any address, dummy or data bytes. For read-type commands the block then drives response bytes on the data-out pin. For write-type commands it waits for chip select to return high. It hands a one-cycle execute pulse to the program/erase engine only if the transfer ended on a whole byte and was long enough.

The chip-select, serial-clock and data-in pins are brought into the system clock domain through a short synchronizer, and every serial edge becomes a single-cycle pulse. The system clock must be at least eight times faster than the serial clock, so each serial clock half-period lasts at least 4 system cycles. Array bytes are fetched on a fixed-latency stream. `rd_req` presents `rd_addr`, and the back end must return the byte on `rd_data` in the next cycle. There is no back-pressure in either direction, because the host's serial clock cannot be paused. Program data bytes likewise leave as `pgm_valid`/`pgm_data` beats with no ready signal. The back end must buffer them and act only on the execute pulse.

The busy flag from the write/erase engine is sampled when an opcode completes. Only status reads are honoured while it is high.

Top module: `sflash_front`

## Requirements
- R1: Opcodes are taken MSB first, with the first bit sampled on the first rising serial clock after chip select falls. The bit and byte counters restart on every chip-select fall.
- R2: Opcode 0x05 returns the status byte {st_flags[6:0], busy} repeatedly, refreshed at each byte start. It answers even while busy, so bit 0 shows the live busy flag.
- R3: Opcode 0x03 takes 3 address bytes MSB first. It then issues one `rd_req` per output byte, starting at that address and incrementing by one. Each byte returned on `rd_data` the cycle after `rd_req` is shifted out MSB first.
- R4: Opcode 0x0B behaves like 0x03 but inserts one dummy byte after the address before output begins.
- R5: Opcode 0x9F outputs DEV_ID[23:16], DEV_ID[15:8], DEV_ID[7:0], then 0x00. Opcode 0xAB outputs SIG repeatedly after 3 dummy bytes, and on chip-select rise issues execute code 8 whatever the bit count.
- R6: Data out changes only after a falling serial clock edge. `dout_oe` is low whenever chip select is high and whenever no response is being driven.
- R7: The write-type opcodes 0x06, 0x04, 0x01, 0x02, 0xD8, 0xC7 and 0xB9 issue a one-cycle `exec_valid` on chip-select rise. They use codes 1, 2, 3, 4, 5, 6 and 7 respectively. `exec_addr` carries the address and `exec_data` carries the 0x01 data byte.
- R8: A write-type command whose chip-select rise is not at an exact multiple of eight clocks gives no execute pulse.
- R9: A write-type command shorter than its minimum length gives no execute pulse. The minimum is 1 byte for 0x06/0x04/0xC7/0xB9, 2 bytes for 0x01, 4 bytes for 0xD8 and 5 bytes for 0x02.
- R10: Every complete byte after the address of an 0x02 command is sent as one `pgm_valid` beat.
- R11: If busy is high when the opcode completes, any command other than 0x05 is ignored: no `rd_req`, no `pgm_valid`, no execute pulse, and `dout_oe` stays low.
- R12: An unknown opcode is ignored, along with everything after it, until chip select rises. The next transaction decodes normally.
- R13: A read-type transfer may end at any bit. It then issues no execute pulse and leaves the next transaction unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock (mode 0) |
| mosi | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for dout |
| busy | input | 1 | Write/erase engine busy |
| st_flags | input | 7 | Upper status bits |
| rd_req | output | 1 | Array byte fetch request |
| rd_addr | output | 24 | Fetch address |
| rd_data | input | 8 | Fetched byte, valid one cycle after rd_req |
| pgm_valid | output | 1 | Program data beat |
| pgm_data | output | 8 | Program data byte |
| exec_valid | output | 1 | Execute pulse |
| exec_cmd | output | 4 | Execute command code |
| exec_addr | output | 24 | Execute address |
| exec_data | output | 8 | Status write byte |

## Verification
The bench sweeps all 256 opcodes through a one-byte transfer. A decoder that misread bit order or coded an opcode wrongly would pulse execute for the wrong codes. It cuts a write-enable transfer at every length from 1 to 20 bits and an erase at every byte count, so a design that counted bits modulo the wrong value or skipped the length check would execute on a ragged or short transfer. Reads that cross an address carry, reads aborted mid-bit, and commands sent while busy expose designs that fetch the wrong byte, stall on abort, or disturb the engine during a write cycle.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  typedef enum logic [3:0] {
    C_NONE = 4'd0,
    C_WREN = 4'd1,
    C_WRDI = 4'd2,
    C_WRSR = 4'd3,
    C_PP   = 4'd4,
    C_SE   = 4'd5,
    C_BE   = 4'd6,
    C_DP   = 4'd7,
    C_RES  = 4'd8,
    C_RDSR = 4'd9,
    C_READ = 4'd10,
    C_FAST = 4'd11,
    C_RDID = 4'd12
  } cmd_e;

  localparam int unsigned SIG_DUMMY = 3;

  function automatic cmd_e op_decode(input logic [7:0] op);
    case (op)
      8'h06:   return C_WREN;
      8'h04:   return C_WRDI;
      8'h01:   return C_WRSR;
      8'h02:   return C_PP;
      8'hD8:   return C_SE;
      8'hC7:   return C_BE;
      8'hB9:   return C_DP;
      8'hAB:   return C_RES;
      8'h05:   return C_RDSR;
      8'h03:   return C_READ;
      8'h0B:   return C_FAST;
      8'h9F:   return C_RDID;
      default: return C_NONE;
    endcase
  endfunction

  // bytes received before the first response byte is driven
  function automatic int unsigned hdr_len(input cmd_e c, input int unsigned ab);
    case (c)
      C_RDSR, C_RDID: return 1;
      C_READ:         return 1 + ab;
      C_FAST:         return 2 + ab;
      C_RES:          return 1 + SIG_DUMMY;
      default:        return 0;
    endcase
  endfunction

  // minimum bytes before a chip-select rise may commit
  function automatic int unsigned min_len(input cmd_e c, input int unsigned ab);
    case (c)
      C_WREN, C_WRDI, C_BE, C_DP, C_RES: return 1;
      C_WRSR:  return 2;
      C_SE:    return 1 + ab;
      C_PP:    return 2 + ab;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_wr(input cmd_e c);
    return c inside {C_WREN, C_WRDI, C_WRSR, C_PP, C_SE, C_BE, C_DP};
  endfunction

endpackage

// File: rtl/sflash_sync.sv
module sflash_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic sel,
  output logic sel_fall,
  output logic sel_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam int L = STAGES - 1;

  logic [L:0] cs_p, sck_p, mo_p;
  logic cs_d, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '0;
      mo_p  <= '0;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_p  <= {cs_p[L-1:0], cs_n};
      sck_p <= {sck_p[L-1:0], sck};
      mo_p  <= {mo_p[L-1:0], mosi};
      cs_d  <= cs_p[L];
      sck_d <= sck_p[L];
    end
  end

  assign sel      = !cs_p[L];
  assign sel_fall = cs_d && !cs_p[L];
  assign sel_rise = !cs_d && cs_p[L];
  assign sck_rise = !sck_d && sck_p[L];
  assign sck_fall = sck_d && !sck_p[L];
  assign mosi_s   = mo_p[L];
endmodule

// File: rtl/sflash_rx.sv
module sflash_rx #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             sel_fall,
  input  logic             sck_rise,
  input  logic             mosi_s,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] byte_idx,
  output logic [CNT_W-1:0] nbytes,
  output logic [2:0]       bit_ph
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [6:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bit_ph    <= '0;
      nbytes    <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
      byte_idx  <= '0;
    end else if (sel_fall) begin
      bit_ph    <= '0;
      nbytes    <= '0;
      byte_done <= 1'b0;
    end else if (sel && sck_rise) begin
      sh     <= {sh[5:0], mosi_s};
      bit_ph <= bit_ph + 3'd1;
      if (bit_ph == 3'd7) begin
        byte_done <= 1'b1;
        byte_val  <= {sh, mosi_s};
        byte_idx  <= nbytes;
        if (nbytes != SAT) nbytes <= nbytes + 1'b1;
      end else begin
        byte_done <= 1'b0;
      end
    end else begin
      byte_done <= 1'b0;
    end
  end

  assert_bits_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_fall) |-> (bit_ph == 3'd0 && nbytes == '0));

endmodule

// File: rtl/sflash_ctrl.sv
module sflash_ctrl
  import sflash_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 4,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              byte_done,
  input  logic [7:0]        byte_val,
  input  logic [CNT_W-1:0]  byte_idx,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic [2:0]        bit_ph,
  input  logic              busy,
  output cmd_e              cmd,
  output logic              rsp_on,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pgm_valid,
  output logic [7:0]        pgm_data,
  output logic              exec_valid,
  output cmd_e              exec_cmd,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [7:0]        exec_data
);
  cmd_e              cmd_q, dec;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wr_q;
  logic              rsp_q;
  logic              fetch, is_addr, hdr_last, commit;
  int                idx;

  always_comb begin
    idx = int'(byte_idx);
    dec = op_decode(byte_val);
    if (busy && dec != C_RDSR) dec = C_NONE;
    is_addr  = (cmd_q inside {C_READ, C_FAST, C_PP, C_SE}) && idx >= 1 && idx <= ADDR_BYTES;
    hdr_last = (idx + 1) == int'(hdr_len(cmd_q, ADDR_BYTES));
    fetch    = byte_done && (cmd_q inside {C_READ, C_FAST}) && (rsp_q || hdr_last);
    commit   = sel_rise && int'(nbytes) >= int'(min_len(cmd_q, ADDR_BYTES)) &&
               ((is_wr(cmd_q) && bit_ph == 3'd0) || cmd_q == C_RES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= C_NONE;
      addr_q     <= '0;
      wr_q       <= '0;
      rsp_q      <= 1'b0;
      rd_req     <= 1'b0;
      pgm_valid  <= 1'b0;
      pgm_data   <= '0;
      exec_valid <= 1'b0;
      exec_cmd   <= C_NONE;
      exec_addr  <= '0;
      exec_data  <= '0;
    end else begin
      rd_req     <= fetch;
      pgm_valid  <= 1'b0;
      exec_valid <= 1'b0;
      if (rd_req) addr_q <= addr_q + 1'b1;
      if (sel_fall) begin
        cmd_q <= C_NONE;
        rsp_q <= 1'b0;
      end else if (byte_done) begin
        if (idx == 0) begin
          cmd_q <= dec;
          if (hdr_len(dec, ADDR_BYTES) == 1) rsp_q <= 1'b1;
        end else begin
          if (is_addr) addr_q <= {addr_q[ADDR_W-9:0], byte_val};
          if (cmd_q == C_WRSR && idx == 1) wr_q <= byte_val;
          if (cmd_q == C_PP && idx > ADDR_BYTES) begin
            pgm_valid <= 1'b1;
            pgm_data  <= byte_val;
          end
          if (hdr_last && cmd_q != C_NONE) rsp_q <= 1'b1;
        end
      end
      if (commit) begin
        exec_valid <= 1'b1;
        exec_cmd   <= cmd_q;
        exec_addr  <= addr_q;
        exec_data  <= wr_q;
      end
    end
  end

  assign cmd     = cmd_q;
  assign rsp_on  = rsp_q;
  assign rd_addr = addr_q;

  assert_exec_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> $past(sel_rise));

  assert_exec_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_cmd != C_RES) |-> $past(bit_ph) == 3'd0);

  assert_fetch_only_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (cmd_q == C_READ || cmd_q == C_FAST));

  assert_pgm_only_program_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid |-> cmd_q == C_PP);

  assert_unknown_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_q == C_NONE) |-> !(rd_req || pgm_valid || exec_valid));

endmodule

// File: rtl/sflash_tx.sv
module sflash_tx
  import sflash_pkg::*;
#(
  parameter logic [23:0] DEV_ID = 24'hC22013,
  parameter logic [7:0]  SIG    = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sel_fall,
  input  logic       sck_fall,
  input  logic       rsp_on,
  input  cmd_e       cmd,
  input  logic [2:0] bit_ph,
  input  logic       busy,
  input  logic [6:0] st_flags,
  input  logic       rd_req,
  input  logic [7:0] rd_data,
  output logic       dout,
  output logic       oe
);
  logic [7:0] sh, hold, nxt;
  logic       pend;
  logic [1:0] outc;

  always_comb begin
    case (cmd)
      C_RDSR: nxt = {st_flags, busy};
      C_RES:  nxt = SIG;
      C_READ, C_FAST: nxt = hold;
      C_RDID: begin
        case (outc)
          2'd0:    nxt = DEV_ID[23:16];
          2'd1:    nxt = DEV_ID[15:8];
          2'd2:    nxt = DEV_ID[7:0];
          default: nxt = 8'h00;
        endcase
      end
      default: nxt = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      hold <= '0;
      pend <= 1'b0;
      outc <= '0;
      oe   <= 1'b0;
    end else begin
      pend <= rd_req;
      if (pend) hold <= rd_data;
      if (sel_fall) begin
        oe   <= 1'b0;
        outc <= '0;
      end else if (!sel) begin
        oe <= 1'b0;
      end else if (sck_fall && rsp_on) begin
        if (bit_ph == 3'd0) begin
          sh <= nxt;
          oe <= 1'b1;
          if (outc != 2'd3) outc <= outc + 2'd1;
        end else begin
          sh <= {sh[6:0], 1'b0};
        end
      end
    end
  end

  assign dout = sh[7];

  assert_dout_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && !$past(sck_fall)) |-> $stable(dout));

endmodule

// File: rtl/sflash_front.sv
module sflash_front
  import sflash_pkg::*;
#(
  parameter int          ADDR_BYTES  = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [23:0] DEV_ID      = 24'hC22013,
  parameter logic [7:0]  SIG         = 8'h11,
  localparam int         ADDR_W      = 8 * ADDR_BYTES,
  localparam int         CNT_W       = $clog2(ADDR_BYTES + 3) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              dout,
  output logic              dout_oe,
  input  logic              busy,
  input  logic [6:0]        st_flags,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              pgm_valid,
  output logic [7:0]        pgm_data,
  output logic              exec_valid,
  output logic [3:0]        exec_cmd,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [7:0]        exec_data
);
  logic             sel, sel_fall, sel_rise, sck_rise, sck_fall, mosi_s;
  logic             byte_done, rsp_on;
  logic [7:0]       byte_val;
  logic [CNT_W-1:0] byte_idx, nbytes;
  logic [2:0]       bit_ph;
  cmd_e             cmd, exec_c;

  sflash_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .sel(sel), .sel_fall(sel_fall), .sel_rise(sel_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  sflash_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sel_fall(sel_fall),
    .sck_rise(sck_rise), .mosi_s(mosi_s), .byte_done(byte_done),
    .byte_val(byte_val), .byte_idx(byte_idx), .nbytes(nbytes), .bit_ph(bit_ph)
  );

  sflash_ctrl #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_fall(sel_fall), .sel_rise(sel_rise),
    .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx),
    .nbytes(nbytes), .bit_ph(bit_ph), .busy(busy), .cmd(cmd), .rsp_on(rsp_on),
    .rd_req(rd_req), .rd_addr(rd_addr), .pgm_valid(pgm_valid),
    .pgm_data(pgm_data), .exec_valid(exec_valid), .exec_cmd(exec_c),
    .exec_addr(exec_addr), .exec_data(exec_data)
  );

  sflash_tx #(.DEV_ID(DEV_ID), .SIG(SIG)) u_tx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sel_fall(sel_fall),
    .sck_fall(sck_fall), .rsp_on(rsp_on), .cmd(cmd), .bit_ph(bit_ph),
    .busy(busy), .st_flags(st_flags), .rd_req(rd_req), .rd_data(rd_data),
    .dout(dout), .oe(dout_oe)
  );

  assign exec_cmd = exec_c;

  assert_oe_off_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && $past(!sel)) |-> !dout_oe);

endmodule

// File: tb/sflash_front_bench.sv
module sflash_front_bench;
  localparam int HP = 8;
  localparam logic [23:0] ID = 24'hC22013;
  localparam logic [7:0]  SG = 8'h11;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, busy = 0;
  logic [6:0] st_flags = 7'h2A;
  logic [7:0] rd_data = 0;
  logic dout, dout_oe, rd_req, pgm_valid, exec_valid;
  logic [23:0] rd_addr, exec_addr;
  logic [7:0] pgm_data, exec_data;
  logic [3:0] exec_cmd;

  int checks = 0, fails = 0, exec_n = 0, pgm_n = 0, rd_n = 0;
  logic [3:0] l_cmd; logic [23:0] l_addr, rd_first; logic [7:0] l_data;
  logic [7:0] pgm_buf [8];
  logic oe_seen = 0, done = 0;

  always #10 clk = ~clk;

  sflash_front u_sflash_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .dout(dout), .dout_oe(dout_oe), .busy(busy), .st_flags(st_flags),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .pgm_valid(pgm_valid), .pgm_data(pgm_data), .exec_valid(exec_valid),
    .exec_cmd(exec_cmd), .exec_addr(exec_addr), .exec_data(exec_data)
  );

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (rd_req) begin
      rd_data <= mem_f(rd_addr);
      if (rd_n == 0) rd_first <= rd_addr;
      rd_n <= rd_n + 1;
    end
    if (pgm_valid) begin
      if (pgm_n < 8) pgm_buf[pgm_n] <= pgm_data;
      pgm_n <= pgm_n + 1;
    end
    if (exec_valid) begin
      exec_n <= exec_n + 1;
      l_cmd <= exec_cmd; l_addr <= exec_addr; l_data <= exec_data;
    end
    if (dout_oe) oe_seen <= 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    tick(2);
    exec_n = 0; pgm_n = 0; rd_n = 0; oe_seen = 0;
  endtask

  task automatic sel_lo();
    cs_n = 0; tick(HP);
  endtask

  task automatic sel_hi();
    tick(HP); cs_n = 1; tick(3 * HP);
  endtask

  task automatic bitx(input logic b, output logic r);
    mosi = b; tick(HP);
    r = dout;
    sck = 1; tick(HP);
    sck = 0;
  endtask

  task automatic bytex(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      bitx(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    bytex(tx, d);
  endtask

  function automatic logic [3:0] wr_code(input logic [7:0] op);
    case (op)
      8'h06: return 4'd1; 8'h04: return 4'd2; 8'hC7: return 4'd6;
      8'hB9: return 4'd7; 8'hAB: return 4'd8; default: return 4'd0;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(5); rst_n = 1; tick(5);
    // reset state, R6
    chk(dout_oe, 0, "R6 reset oe");
    chk({exec_valid, rd_req, pgm_valid}, 0, "R6 reset strobes");

    // R1 R7 R12: every opcode as a single byte
    for (int op = 0; op < 256; op++) begin
      clr(); sel_lo(); send(op[7:0]); sel_hi();
      chk(exec_n, (wr_code(op[7:0]) != 0) ? 1 : 0, "R1/R7/R12 opcode sweep count");
      if (wr_code(op[7:0]) != 0) chk(l_cmd, wr_code(op[7:0]), "R7 opcode sweep code");
    end

    // R8: write enable cut at every bit count
    for (int n = 1; n <= 20; n++) begin
      logic [23:0] v = 24'h060000;
      clr(); sel_lo();
      for (int i = 0; i < n; i++) begin
        logic r;
        bitx(v[23 - i], r);
      end
      sel_hi();
      chk(exec_n, (n % 8 == 0) ? 1 : 0, "R8 boundary sweep");
    end

    // R9: sector erase with 1..6 bytes
    for (int nb = 1; nb <= 6; nb++) begin
      logic [7:0] seq [6] = '{8'hD8, 8'hA1, 8'hB2, 8'hC3, 8'h00, 8'h00};
      clr(); sel_lo();
      for (int i = 0; i < nb; i++) send(seq[i]);
      sel_hi();
      chk(exec_n, (nb >= 4) ? 1 : 0, "R9 erase length");
      if (nb >= 4) chk({l_cmd, l_addr}, {4'd5, 24'hA1B2C3}, "R9 erase addr");
    end

    // R10: page program
    clr(); sel_lo();
    send(8'h02); send(8'h00); send(8'h01); send(8'hFE);
    send(8'h11); send(8'h22); send(8'h33); sel_hi();
    chk(pgm_n, 3, "R10 beats");
    chk({pgm_buf[0], pgm_buf[1], pgm_buf[2]}, 24'h112233, "R10 data");
    chk({exec_n[3:0], l_cmd, l_addr}, {4'd1, 4'd4, 24'h0001FE}, "R10 exec");

    // R8: program ending 3 bits past a byte
    clr(); sel_lo();
    send(8'h02); send(8'h00); send(8'h00); send(8'h10); send(8'h44);
    for (int i = 0; i < 3; i++) begin
      logic r;
      bitx(1'b1, r);
    end
    sel_hi();
    chk(exec_n, 0, "R8 ragged program");

    // R7: status write
    clr(); sel_lo(); send(8'h01); send(8'h9C); sel_hi();
    chk({exec_n[3:0], l_cmd, l_data}, {4'd1, 4'd3, 8'h9C}, "R7 status write");

    // R3: read across a carry
    clr(); sel_lo();
    send(8'h03); send(8'h12); send(8'h34); send(8'hFE);
    for (int i = 0; i < 4; i++) begin
      bytex(8'h00, d);
      chk(d, mem_f(24'h1234FE + 24'(i)), "R3 read byte");
    end
    sel_hi();
    chk(rd_first, 24'h1234FE, "R3 first address");
    chk(exec_n, 0, "R3 no exec");
    chk(dout_oe, 0, "R6 oe after deselect");

    // R4: fast read with dummy byte
    clr(); sel_lo();
    send(8'h0B); send(8'h00); send(8'h00); send(8'h10); send(8'hFF);
    for (int i = 0; i < 3; i++) begin
      bytex(8'h00, d);
      chk(d, mem_f(24'h000010 + 24'(i)), "R4 fast byte");
    end
    sel_hi();

    // R2: status read, idle then busy
    clr(); sel_lo(); send(8'h05); bytex(8'h00, d); sel_hi();
    chk(d, 8'h54, "R2 status idle");
    busy = 1;
    clr(); sel_lo(); send(8'h05); bytex(8'h00, d); chk(d, 8'h55, "R2 status busy");
    bytex(8'h00, d); chk(d, 8'h55, "R2 status repeat"); sel_hi();

    // R11: everything else ignored while busy
    clr(); sel_lo(); send(8'h03); send(8'h00); send(8'h00); send(8'h00);
    bytex(8'h00, d); sel_hi();
    chk({rd_n[3:0], 3'b0, oe_seen}, 0, "R11 read while busy");
    clr(); sel_lo(); send(8'h02); send(8'h00); send(8'h00); send(8'h00);
    send(8'h77); sel_hi();
    chk({pgm_n[3:0], exec_n[3:0]}, 0, "R11 program while busy");
    clr(); sel_lo(); send(8'h06); sel_hi();
    chk(exec_n, 0, "R11 wren while busy");
    busy = 0;

    // R5: identification and signature
    clr(); sel_lo(); send(8'h9F);
    for (int i = 0; i < 4; i++) begin
      bytex(8'h00, d);
      chk(d, (i < 3) ? ID[23 - 8 * i -: 8] : 8'h00, "R5 id byte");
    end
    sel_hi();
    clr(); sel_lo(); send(8'hAB); send(8'h00); send(8'h00); send(8'h00);
    bytex(8'h00, d); chk(d, SG, "R5 signature");
    bytex(8'h00, d); chk(d, SG, "R5 signature repeat");
    begin logic r; bitx(1'b0, r); end
    sel_hi();
    chk({exec_n[3:0], l_cmd}, {4'd1, 4'd8}, "R5 release exec");

    // R13: read aborted mid-bit, then status works
    clr(); sel_lo(); send(8'h03); send(8'h00); send(8'h00); send(8'h20);
    for (int i = 0; i < 3; i++) begin
      logic r;
      bitx(1'b0, r);
    end
    sel_hi();
    chk(exec_n, 0, "R13 abort no exec");
    clr(); sel_lo(); send(8'h05); bytex(8'h00, d); sel_hi();
    chk(d, 8'h54, "R13 next transfer");

    // R12: unknown opcode swallows a later write enable
    clr(); sel_lo(); send(8'h00); send(8'h06); sel_hi();
    chk(exec_n, 0, "R12 unknown ignored");
    clr(); sel_lo(); send(8'h06); sel_hi();
    chk({exec_n[3:0], l_cmd}, {4'd1, 4'd1}, "R12/R1 recovery");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule